// File: doc/BRIEF.md
# Direct-Select Status Quadrant Multiplexer

This block places the active-low almost-empty flags of a 32-queue buffer onto an 8-bit status bus. The bus shows one group of eight queues (a quadrant) at a time. An external controller picks the quadrant with a quadrant-select strobe and a 5-bit address. The upper 3 address bits name a device and the lower 2 bits name the quadrant inside that device.

Only the device whose static ID matches the upper address bits takes the bus and raises its output enable. A device that sees a selection meant for another ID drops its enable, so several devices can share one bus. A selection may change on every clock. A quadrant request that arrives in the same cycle as a read-queue selection is refused, and an error pulse is raised. When 8 or fewer queues are configured, the first eight flags are driven on the bus at all times.

Top module: `stat_quad_mux`

## Requirements
- R1: While reset is high, and on the first cycle after it, the selected quadrant is 0, the internal drive state is off, and `sel_conflict` is 0. With more than 8 queues configured, `stat_oe` is therefore 0 and `stat_bus` equals `flags_n[7:0]`.
- R2: A clock edge with `quad_sel_stb`=1, `rdq_sel_stb`=0 and `rd_addr[4:2]`==`dev_id` makes `rd_addr[1:0]` the selected quadrant and sets `stat_oe` to 1 from the next cycle on.
- R3: With quadrant q selected, `stat_bus[i]` equals `flags_n[8q+i]` without inversion (0 = almost empty). The bus follows flag changes combinationally, with no clock edge needed.
- R4: A clock edge with `quad_sel_stb`=1, `rdq_sel_stb`=0 and `rd_addr[4:2]`!=`dev_id` clears `stat_oe`, which then stays 0 until the next matching selection. The selected quadrant is kept.
- R5: A clock edge with both `quad_sel_stb` and `rdq_sel_stb` at 1 leaves the quadrant and `stat_oe` unchanged. It sets `sel_conflict` for exactly the following cycle.
- R6: Selections on back-to-back clock edges each take effect, one cycle after their own edge.
- R7: `rdq_sel_stb` alone changes neither the quadrant nor `stat_oe`, and raises no conflict.
- R8: When `queue_count` <= 8, `stat_oe` is 1 and `stat_bus` equals `flags_n[7:0]`, whatever the selection. At 9 or more, R2 to R4 govern the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset |
| flags_n | input | 32 | Per-queue almost-empty flags, active low |
| rd_addr | input | 5 | Device ID [4:2] and quadrant index [1:0] |
| quad_sel_stb | input | 1 | Quadrant selection strobe |
| rdq_sel_stb | input | 1 | Read-queue selection strobe |
| dev_id | input | 3 | Static device ID |
| queue_count | input | 6 | Number of configured queues |
| stat_bus | output | 8 | Selected quadrant's flags |
| stat_oe | output | 1 | Output enable for the shared bus |
| sel_conflict | output | 1 | One-cycle pulse when a quadrant request is refused |

## Verification
The bench sweeps every address against every device ID on consecutive edges. A design that compared the wrong address bits, or that held a selection for more than one cycle, would show the wrong quadrant or the wrong enable. It fires both strobes together with an address that would otherwise move the quadrant. A design missing the lockout would switch quadrants, and one without a one-cycle error pulse would leave `sel_conflict` stuck or silent. It also steps `queue_count` across the 8/9 boundary while the selection points elsewhere. An off-by-one compare there would hand the bus to the selected quadrant, or drop the enable, when the count is exactly 8.

// File: rtl/sqm_pkg.sv
package sqm_pkg;

    localparam int QUEUES_DEF   = 32;
    localparam int LANE_W_DEF   = 8;
    localparam int DEV_ID_W_DEF = 3;

    typedef enum logic [1:0] {
        REQ_NONE    = 2'd0,
        REQ_TAKE    = 2'd1,
        REQ_RELEASE = 2'd2,
        REQ_CLASH   = 2'd3
    } sel_req_e;

    function automatic sel_req_e classify_req(input logic quad_stb,
                                              input logic rdq_stb,
                                              input logic id_hit);
        if (quad_stb && rdq_stb) return REQ_CLASH;
        if (!quad_stb)           return REQ_NONE;
        if (id_hit)              return REQ_TAKE;
        return REQ_RELEASE;
    endfunction

endpackage

// File: rtl/sqm_req_decode.sv
module sqm_req_decode
    import sqm_pkg::*;
#(
    parameter int DEV_ID_W = DEV_ID_W_DEF,
    parameter int QIDX_W   = 2,
    localparam int ADDR_W  = DEV_ID_W + QIDX_W
) (
    input  logic                quad_sel_stb,
    input  logic                rdq_sel_stb,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [DEV_ID_W-1:0] dev_id,
    output sel_req_e            req,
    output logic [QIDX_W-1:0]   req_quad
);
    logic id_hit;

    always_comb begin
        id_hit   = (rd_addr[ADDR_W-1 -: DEV_ID_W] == dev_id);
        req      = classify_req(quad_sel_stb, rdq_sel_stb, id_hit);
        req_quad = rd_addr[QIDX_W-1:0];
    end
endmodule

// File: rtl/sqm_sel_reg.sv
module sqm_sel_reg
    import sqm_pkg::*;
#(
    parameter int QIDX_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  sel_req_e          req,
    input  logic [QIDX_W-1:0] req_quad,
    output logic [QIDX_W-1:0] quad_q,
    output logic              drive_q,
    output logic              clash_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            quad_q  <= '0;
            drive_q <= 1'b0;
            clash_q <= 1'b0;
        end else begin
            clash_q <= (req == REQ_CLASH);
            case (req)
                REQ_TAKE: begin
                    quad_q  <= req_quad;
                    drive_q <= 1'b1;
                end
                REQ_RELEASE: drive_q <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sqm_lane_mux.sv
module sqm_lane_mux #(
    parameter int QUEUES    = 32,
    parameter int LANE_W    = 8,
    localparam int NUM_QUAD = QUEUES / LANE_W,
    localparam int QIDX_W   = $clog2(NUM_QUAD)
) (
    input  logic [QUEUES-1:0] flags_n,
    input  logic [QIDX_W-1:0] quad,
    input  logic              small_cfg,
    output logic [LANE_W-1:0] lane_out
);
    logic [LANE_W-1:0] lanes [NUM_QUAD];

    for (genvar q = 0; q < NUM_QUAD; q++) begin : g_lane
        assign lanes[q] = flags_n[q*LANE_W +: LANE_W];
    end

    always_comb begin
        lane_out = small_cfg ? lanes[0] : lanes[quad];
    end
endmodule

// File: rtl/stat_quad_mux.sv
module stat_quad_mux
    import sqm_pkg::*;
#(
    parameter int QUEUES    = QUEUES_DEF,
    parameter int LANE_W    = LANE_W_DEF,
    parameter int DEV_ID_W  = DEV_ID_W_DEF,
    localparam int NUM_QUAD = QUEUES / LANE_W,
    localparam int QIDX_W   = $clog2(NUM_QUAD),
    localparam int ADDR_W   = DEV_ID_W + QIDX_W,
    localparam int CNT_W    = $clog2(QUEUES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [QUEUES-1:0]   flags_n,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                quad_sel_stb,
    input  logic                rdq_sel_stb,
    input  logic [DEV_ID_W-1:0] dev_id,
    input  logic [CNT_W-1:0]    queue_count,
    output logic [LANE_W-1:0]   stat_bus,
    output logic                stat_oe,
    output logic                sel_conflict
);
    sel_req_e          req;
    logic [QIDX_W-1:0] req_quad;
    logic [QIDX_W-1:0] cur_quad;
    logic              drive_q;
    logic              small_cfg;

    assign small_cfg = (queue_count <= CNT_W'(LANE_W));

    sqm_req_decode #(.DEV_ID_W(DEV_ID_W), .QIDX_W(QIDX_W)) u_dec (
        .quad_sel_stb (quad_sel_stb),
        .rdq_sel_stb  (rdq_sel_stb),
        .rd_addr      (rd_addr),
        .dev_id       (dev_id),
        .req          (req),
        .req_quad     (req_quad)
    );

    sqm_sel_reg #(.QIDX_W(QIDX_W)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .req_quad (req_quad),
        .quad_q   (cur_quad),
        .drive_q  (drive_q),
        .clash_q  (sel_conflict)
    );

    sqm_lane_mux #(.QUEUES(QUEUES), .LANE_W(LANE_W)) u_mux (
        .flags_n   (flags_n),
        .quad      (cur_quad),
        .small_cfg (small_cfg),
        .lane_out  (stat_bus)
    );

    assign stat_oe = drive_q | small_cfg;
endmodule

// File: rtl/sqm_chk.sv
module sqm_chk #(
    parameter int QUEUES    = 32,
    parameter int LANE_W    = 8,
    parameter int DEV_ID_W  = 3,
    localparam int NUM_QUAD = QUEUES / LANE_W,
    localparam int QIDX_W   = $clog2(NUM_QUAD),
    localparam int ADDR_W   = DEV_ID_W + QIDX_W,
    localparam int CNT_W    = $clog2(QUEUES + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic [QUEUES-1:0]   flags_n,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic                quad_sel_stb,
    input logic                rdq_sel_stb,
    input logic [DEV_ID_W-1:0] dev_id,
    input logic [CNT_W-1:0]    queue_count,
    input logic [LANE_W-1:0]   stat_bus,
    input logic                stat_oe,
    input logic                sel_conflict,
    input logic [QIDX_W-1:0]   cur_quad,
    input logic                drive_q
);
    logic hit;
    assign hit = (rd_addr[ADDR_W-1 -: DEV_ID_W] == dev_id);

    // R1
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (cur_quad == '0) && !drive_q && !sel_conflict);

    // R2
    p_take_r2: assert property (@(posedge clk) disable iff (rst)
        (quad_sel_stb && !rdq_sel_stb && hit)
        |=> (cur_quad == $past(rd_addr[QIDX_W-1:0])) && drive_q);

    // R3
    p_lane_map_r3: assert property (@(posedge clk) disable iff (rst)
        (queue_count > CNT_W'(LANE_W))
        |-> (stat_bus == flags_n[cur_quad*LANE_W +: LANE_W]));

    // R4
    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (quad_sel_stb && !rdq_sel_stb && !hit)
        |=> !drive_q && $stable(cur_quad));

    // R5
    p_clash_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (quad_sel_stb && rdq_sel_stb)
        |=> sel_conflict && $stable(cur_quad) && $stable(drive_q));

    // R5
    p_clash_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        !(quad_sel_stb && rdq_sel_stb) |=> !sel_conflict);

    // R7
    p_rdq_only_r7: assert property (@(posedge clk) disable iff (rst)
        (rdq_sel_stb && !quad_sel_stb)
        |=> $stable(cur_quad) && $stable(drive_q));

    // R8
    p_small_cfg_r8: assert property (@(posedge clk) disable iff (rst)
        (queue_count <= CNT_W'(LANE_W))
        |-> stat_oe && (stat_bus == flags_n[LANE_W-1:0]));
endmodule

bind stat_quad_mux sqm_chk #(
    .QUEUES   (QUEUES),
    .LANE_W   (LANE_W),
    .DEV_ID_W (DEV_ID_W)
) u_chk (.*);

// File: tb/stat_quad_mux_tb.sv
module stat_quad_mux_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] flags_n;
    logic [4:0]  rd_addr;
    logic        quad_sel_stb;
    logic        rdq_sel_stb;
    logic [2:0]  dev_id;
    logic [5:0]  queue_count;
    logic [7:0]  stat_bus;
    logic        stat_oe;
    logic        sel_conflict;

    int checks = 0;
    int errors = 0;
    int exp_q  = 0;
    logic exp_oe = 1'b0;
    bit done = 0;

    always #4 clk = ~clk;

    stat_quad_mux u_dut (
        .clk          (clk),
        .rst          (rst),
        .flags_n      (flags_n),
        .rd_addr      (rd_addr),
        .quad_sel_stb (quad_sel_stb),
        .rdq_sel_stb  (rdq_sel_stb),
        .dev_id       (dev_id),
        .queue_count  (queue_count),
        .stat_bus     (stat_bus),
        .stat_oe      (stat_oe),
        .sel_conflict (sel_conflict)
    );

    function automatic logic [7:0] lane_of(input logic [31:0] f, input int q);
        return 8'((f >> (8 * q)) & 32'hFF);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a negedge; the posedge registers; sample at the following negedge
    task automatic cycle(input logic qs, input logic rs, input logic [4:0] a);
        quad_sel_stb = qs;
        rdq_sel_stb  = rs;
        rd_addr      = a;
        @(negedge clk);
        quad_sel_stb = 1'b0;
        rdq_sel_stb  = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        flags_n = 32'hA5C3_1E69;
        rd_addr = '0;
        quad_sel_stb = 1'b0;
        rdq_sel_stb = 1'b0;
        dev_id = 3'd0;
        queue_count = 6'd32;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 oe", 32'(stat_oe), 0);
        chk("R1 conflict", 32'(sel_conflict), 0);
        chk("R1 bus", 32'(stat_bus), 32'(lane_of(flags_n, 0)));

        // R2 R3 R4 R6: every address against every ID, selections back to back
        for (int id = 0; id < 8; id++) begin
            dev_id = 3'(id);
            for (int a = 0; a < 32; a++) begin
                flags_n = 32'h9E37_79B9 * (32'(id) * 32 + 32'(a) + 1);
                cycle(1'b1, 1'b0, 5'(a));
                if ((a >> 2) == id) begin
                    exp_q  = a & 3;
                    exp_oe = 1'b1;
                end else begin
                    exp_oe = 1'b0;
                end
                chk("R2/R4/R6 oe", 32'(stat_oe), 32'(exp_oe));
                chk("R3/R6 bus", 32'(stat_bus), 32'(lane_of(flags_n, exp_q)));
            end
        end

        // R3 combinational follow, active-low pass-through
        dev_id = 3'd5;
        cycle(1'b1, 1'b0, {3'd5, 2'd2});
        exp_q = 2; exp_oe = 1'b1;
        flags_n = 32'h00FE_0000;
        #1;
        chk("R3 follow", 32'(stat_bus), 32'hFE);
        flags_n = 32'h0001_0000;
        #1;
        chk("R3 follow2", 32'(stat_bus), 32'h01);
        @(negedge clk);

        // R5 clash: matching address for quadrant 3 must be refused
        flags_n = 32'h1122_3344;
        cycle(1'b1, 1'b1, {3'd5, 2'd3});
        chk("R5 conflict", 32'(sel_conflict), 1);
        chk("R5 quad held", 32'(stat_bus), 32'(lane_of(flags_n, 2)));
        chk("R5 oe held", 32'(stat_oe), 1);
        @(negedge clk);
        chk("R5 pulse end", 32'(sel_conflict), 0);
        // R5 clash with mismatching ID must not release
        cycle(1'b1, 1'b1, {3'd1, 2'd0});
        chk("R5 no release", 32'(stat_oe), 1);
        chk("R5 conflict2", 32'(sel_conflict), 1);

        // R7 read-queue strobe alone
        cycle(1'b0, 1'b1, {3'd5, 2'd0});
        chk("R7 quad", 32'(stat_bus), 32'(lane_of(flags_n, 2)));
        chk("R7 oe", 32'(stat_oe), 1);
        chk("R7 conflict", 32'(sel_conflict), 0);

        // R8 small configuration boundary
        queue_count = 6'd8;
        #1;
        chk("R8 count8 bus", 32'(stat_bus), 32'(lane_of(flags_n, 0)));
        chk("R8 count8 oe", 32'(stat_oe), 1);
        cycle(1'b1, 1'b0, {3'd2, 2'd1});
        chk("R8 mismatch oe", 32'(stat_oe), 1);
        chk("R8 mismatch bus", 32'(stat_bus), 32'(lane_of(flags_n, 0)));
        queue_count = 6'd9;
        #1;
        chk("R8 count9 oe", 32'(stat_oe), 0);
        chk("R8 count9 bus", 32'(stat_bus), 32'(lane_of(flags_n, 2)));
        queue_count = 6'd1;
        cycle(1'b1, 1'b0, {3'd5, 2'd3});
        chk("R8 count1 bus", 32'(stat_bus), 32'(lane_of(flags_n, 0)));
        queue_count = 6'd32;
        #1;
        chk("R8 count32 bus", 32'(stat_bus), 32'(lane_of(flags_n, 3)));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule